// File: doc/BRIEF.md
# Decode Operand Bypass Selector

This block sits in the decode stage of a five-stage in-order pipeline and picks the two operand values that travel on to execute. For each operand it compares the source register ID against the destinations of the instructions in execute, memory and write-back. When a later stage is about to write that register, its value is taken in place of the stale register-file read data. When several stages match, the value from the youngest producer wins, which keeps results the same as serial execution.

Call and jump instructions use operand A to carry their incremented PC, so for those classes operand A bypasses the forwarding chain completely. Register ID 0xF means "no register" and never matches. The execute-stage destination is supplied already adjusted for a move whose condition failed, so such a move presents 0xF and forwards nothing. The block is purely combinational. A clock and reset are present only for the bound checker.

Top module: `dec_bypass_top`

## Requirements
- R1: When the decode instruction class is CALL (2'd1) or JUMP (2'd2), `opnd_a` equals `dec_next_pc`, whatever the source and destination IDs are. Classes OTHER (2'd0) and RET (2'd3) do not override.
- R2: When operand A is not overridden, `opnd_a` takes the first matching source in this order: execute ALU result (`ex_dst_e` vs `ex_alu_val`), memory load data (`mem_dst_m`), memory ALU result (`mem_dst_e`), write-back load data (`wb_dst_m`), write-back ALU result (`wb_dst_e`).
- R3: Operand B uses the same five-source priority as R2, with no PC override for any class.
- R4: When no stage destination equals the source ID, the operand equals the register-file read value for that port.
- R5: Source or destination ID 4'hF never produces a match. A source ID of 0xF yields the register-file value. A stage with destination 0xF is skipped.
- R6: When two or more stages target the same register, the operand comes from the youngest of them (execute before memory before write-back; within a stage the load value before the ALU value).
- R7: A failed conditional move in execute, presented as `ex_dst_e` = 0xF, does not forward. The operand falls through to the next matching older stage.
- R8: Operand A and operand B are selected independently. Each uses only its own source ID and register-file value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock used only by the bound checker |
| rst_n | input | 1 | Active-low reset for the checker |
| dec_cls | input | 2 | Decode instruction class: 0 other, 1 call, 2 jump, 3 ret |
| dec_next_pc | input | DW | Incremented PC of the decode instruction |
| src_a | input | 4 | Source register ID for operand A |
| src_b | input | 4 | Source register ID for operand B |
| rf_a | input | DW | Register-file read data for A |
| rf_b | input | DW | Register-file read data for B |
| ex_dst_e | input | 4 | Execute destination (condition-adjusted) |
| ex_alu_val | input | DW | ALU result being computed in execute |
| mem_dst_e | input | 4 | Memory-stage ALU destination |
| mem_alu_val | input | DW | Memory-stage ALU result |
| mem_dst_m | input | 4 | Memory-stage load destination |
| mem_load_val | input | DW | Data read from memory this cycle |
| wb_dst_e | input | 4 | Write-back ALU destination |
| wb_alu_val | input | DW | Write-back ALU result |
| wb_dst_m | input | 4 | Write-back load destination |
| wb_load_val | input | DW | Write-back loaded value |
| opnd_a | output | DW | Selected operand A |
| opnd_b | output | DW | Selected operand B |

## Verification
The hardest case to reach is one where several stages hold the same destination and it equals a live source ID. Purely random 4-bit IDs seldom line up across five destinations at once. The stimulus therefore draws destinations from a narrow pool of two or three register IDs mixed with 0xF, so that multi-stage collisions, NONE entries and failed moves in execute all occur often. Directed cases then force each level of the chain to be the winner in turn, for both operands and under every instruction class.

// File: rtl/dec_bypass_pkg.sv
package dec_bypass_pkg;
  localparam int unsigned REG_W = 4;
  localparam logic [REG_W-1:0] REG_NONE = 4'hF;
  localparam int unsigned N_SRC = 5;

  typedef enum logic [1:0] {
    CLS_OTHER = 2'd0,
    CLS_CALL  = 2'd1,
    CLS_JUMP  = 2'd2,
    CLS_RET   = 2'd3
  } dec_cls_e;

  typedef logic [REG_W-1:0] reg_id_t;

  // a destination matches a source only when both name a real register
  function automatic logic id_hit(input reg_id_t src, input reg_id_t dst);
    return (src != REG_NONE) && (dst == src);
  endfunction

  function automatic logic uses_pc(input logic [1:0] cls);
    return (cls == CLS_CALL) || (cls == CLS_JUMP);
  endfunction
endpackage

// File: rtl/dec_bypass_match.sv
module dec_bypass_match
  import dec_bypass_pkg::*;
#(
  parameter int unsigned NS = N_SRC
) (
  input  logic [REG_W-1:0]    src,
  input  logic [NS*REG_W-1:0] dsts,
  output logic [NS-1:0]       hits
);
  for (genvar g = 0; g < NS; g++) begin : g_cmp
    assign hits[g] = id_hit(src, dsts[g*REG_W +: REG_W]);
  end
endmodule

// File: rtl/dec_bypass_prio.sv
module dec_bypass_prio #(
  parameter int unsigned NS = 5
) (
  input  logic [NS-1:0] hits,
  output logic [NS-1:0] grant
);
  // index 0 is the youngest producer and wins
  always_comb begin
    grant = '0;
    for (int i = NS - 1; i >= 0; i--) begin
      if (hits[i]) grant = '0;
      if (hits[i]) grant[i] = 1'b1;
    end
  end
endmodule

// File: rtl/dec_bypass_mux.sv
module dec_bypass_mux #(
  parameter int unsigned DW = 32,
  parameter int unsigned NS = 5
) (
  input  logic [NS-1:0]    grant,
  input  logic [NS*DW-1:0] vals,
  input  logic [DW-1:0]    dflt,
  output logic [DW-1:0]    y
);
  logic [DW-1:0] orv;
  always_comb begin
    orv = '0;
    for (int i = 0; i < NS; i++)
      orv = orv | (vals[i*DW +: DW] & {DW{grant[i]}});
  end
  assign y = (|grant) ? orv : dflt;
endmodule

// File: rtl/dec_bypass_top.sv
module dec_bypass_top
  import dec_bypass_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    dec_cls,
  input  logic [DW-1:0] dec_next_pc,
  input  logic [3:0]    src_a,
  input  logic [3:0]    src_b,
  input  logic [DW-1:0] rf_a,
  input  logic [DW-1:0] rf_b,
  input  logic [3:0]    ex_dst_e,
  input  logic [DW-1:0] ex_alu_val,
  input  logic [3:0]    mem_dst_e,
  input  logic [DW-1:0] mem_alu_val,
  input  logic [3:0]    mem_dst_m,
  input  logic [DW-1:0] mem_load_val,
  input  logic [3:0]    wb_dst_e,
  input  logic [DW-1:0] wb_alu_val,
  input  logic [3:0]    wb_dst_m,
  input  logic [DW-1:0] wb_load_val,
  output logic [DW-1:0] opnd_a,
  output logic [DW-1:0] opnd_b
);
  localparam int unsigned NS = N_SRC;

  logic [NS*REG_W-1:0] dst_vec;
  logic [NS*DW-1:0]    val_vec;
  assign dst_vec = {wb_dst_e, wb_dst_m, mem_dst_e, mem_dst_m, ex_dst_e};
  assign val_vec = {wb_alu_val, wb_load_val, mem_alu_val, mem_load_val, ex_alu_val};

  logic [NS-1:0] hit_a, hit_b, gnt_a, gnt_b;
  logic [DW-1:0] fwd_a, fwd_b;
  logic          pc_sel_a;

  dec_bypass_match #(.NS(NS)) u_ma (.src(src_a), .dsts(dst_vec), .hits(hit_a));
  dec_bypass_match #(.NS(NS)) u_mb (.src(src_b), .dsts(dst_vec), .hits(hit_b));
  dec_bypass_prio  #(.NS(NS)) u_pa (.hits(hit_a), .grant(gnt_a));
  dec_bypass_prio  #(.NS(NS)) u_pb (.hits(hit_b), .grant(gnt_b));
  dec_bypass_mux #(.DW(DW), .NS(NS)) u_xa (.grant(gnt_a), .vals(val_vec), .dflt(rf_a), .y(fwd_a));
  dec_bypass_mux #(.DW(DW), .NS(NS)) u_xb (.grant(gnt_b), .vals(val_vec), .dflt(rf_b), .y(fwd_b));

  assign pc_sel_a = uses_pc(dec_cls);
  assign opnd_a   = pc_sel_a ? dec_next_pc : fwd_a;
  assign opnd_b   = fwd_b;
endmodule

// File: rtl/dec_bypass_chk.sv
module dec_bypass_chk #(
  parameter int unsigned DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    dec_cls,
  input logic [DW-1:0] dec_next_pc,
  input logic [3:0]    src_a,
  input logic [3:0]    src_b,
  input logic [DW-1:0] rf_a,
  input logic [DW-1:0] rf_b,
  input logic [3:0]    ex_dst_e,
  input logic [DW-1:0] ex_alu_val,
  input logic [3:0]    mem_dst_m,
  input logic [DW-1:0] mem_load_val,
  input logic [3:0]    wb_dst_e,
  input logic [DW-1:0] wb_alu_val,
  input logic [DW-1:0] opnd_a,
  input logic [DW-1:0] opnd_b,
  input logic [4:0]    gnt_a,
  input logic [4:0]    gnt_b
);
  logic pc_cls;
  assign pc_cls = (dec_cls == 2'd1) || (dec_cls == 2'd2);

  // R1
  pc_override_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pc_cls |-> (opnd_a == dec_next_pc));
  // R2
  ex_first_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pc_cls && src_a != 4'hF && ex_dst_e == src_a) |-> (opnd_a == ex_alu_val));
  // R3
  ex_first_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (src_b != 4'hF && ex_dst_e == src_b) |-> (opnd_b == ex_alu_val));
  // R4
  rf_default_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_b == 5'd0) |-> (opnd_b == rf_b));
  // R5
  none_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (src_b == 4'hF) |-> (opnd_b == rf_b));
  // R6
  single_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt_a) && $onehot0(gnt_b));
  // R7
  mem_load_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (src_b != 4'hF && ex_dst_e == 4'hF && mem_dst_m == src_b) |-> (opnd_b == mem_load_val));
  // R8
  wb_alu_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pc_cls && gnt_a == 5'b10000) |-> (opnd_a == wb_alu_val && wb_dst_e == src_a));
endmodule

bind dec_bypass_top dec_bypass_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .dec_cls(dec_cls), .dec_next_pc(dec_next_pc),
  .src_a(src_a), .src_b(src_b), .rf_a(rf_a), .rf_b(rf_b),
  .ex_dst_e(ex_dst_e), .ex_alu_val(ex_alu_val),
  .mem_dst_m(mem_dst_m), .mem_load_val(mem_load_val),
  .wb_dst_e(wb_dst_e), .wb_alu_val(wb_alu_val),
  .opnd_a(opnd_a), .opnd_b(opnd_b), .gnt_a(gnt_a), .gnt_b(gnt_b)
);

// File: tb/sim_dec_bypass_top.sv
module sim_dec_bypass_top;
  localparam int DW = 32;
  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [1:0] cls;
  logic [DW-1:0] npc, rfa, rfb, exv, mav, mlv, wav, wlv, oa, ob;
  logic [3:0] sa, sb, exd, med, mmd, wed, wmd;
  int n_chk = 0, n_bad = 0;

  dec_bypass_top #(.DW(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .dec_cls(cls), .dec_next_pc(npc),
    .src_a(sa), .src_b(sb), .rf_a(rfa), .rf_b(rfb),
    .ex_dst_e(exd), .ex_alu_val(exv), .mem_dst_e(med), .mem_alu_val(mav),
    .mem_dst_m(mmd), .mem_load_val(mlv), .wb_dst_e(wed), .wb_alu_val(wav),
    .wb_dst_m(wmd), .wb_load_val(wlv), .opnd_a(oa), .opnd_b(ob));

  // reference: walk stages oldest to youngest, later overwrite wins
  function automatic logic [DW-1:0] ref_op(input logic [3:0] s, input logic [DW-1:0] rf);
    logic [DW-1:0] r = rf;
    if (s == 4'hF) return rf;
    if (wed == s) r = wav;
    if (wmd == s) r = wlv;
    if (med == s) r = mav;
    if (mmd == s) r = mlv;
    if (exd == s) r = exv;
    return r;
  endfunction

  task automatic check(input string req, input logic [DW-1:0] got, input logic [DW-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic apply_and_check(input string req);
    @(posedge clk); #5;
    check(req, oa, (cls == 2'd1 || cls == 2'd2) ? npc : ref_op(sa, rfa));
    check(req, ob, ref_op(sb, rfb));
  endtask

  task automatic base();
    cls = 2'd0; npc = 32'h0000_1004; rfa = 32'hAAAA_0000; rfb = 32'hBBBB_0000;
    exv = 32'hE0E0_0001; mlv = 32'h3131_0002; mav = 32'h3E3E_0003;
    wlv = 32'h5151_0004; wav = 32'h5E5E_0005;
    exd = 4'hF; med = 4'hF; mmd = 4'hF; wed = 4'hF; wmd = 4'hF;
    sa = 4'd1; sb = 4'd2;
  endtask

  function automatic logic [3:0] pick(input logic [3:0] a, input logic [3:0] b);
    int k = $urandom_range(0, 3);
    return (k == 0) ? a : (k == 1) ? b : (k == 2) ? 4'hF : 4'($urandom_range(0, 15));
  endfunction

  initial begin
    void'($urandom(32'd12345));
    base();
    repeat (2) @(posedge clk);
    #5;
    // R4: nothing matches, register file data passes
    check("R4", oa, rfa); check("R4", ob, rfb);
    rst_n = 1'b1;

    // R2, R6: each level wins in turn for A
    base(); wed = 4'd1; apply_and_check("R2");
    check("R2", oa, 32'h5E5E_0005);
    wmd = 4'd1; apply_and_check("R6"); check("R6", oa, 32'h5151_0004);
    med = 4'd1; apply_and_check("R6"); check("R6", oa, 32'h3E3E_0003);
    mmd = 4'd1; apply_and_check("R6"); check("R6", oa, 32'h3131_0002);
    exd = 4'd1; apply_and_check("R2"); check("R2", oa, 32'hE0E0_0001);
    // R7: failed move in execute falls through to memory load
    exd = 4'hF; apply_and_check("R7"); check("R7", oa, 32'h3131_0002);
    // R3: B has same chain, all stages on reg 2
    base(); exd = 4'd2; med = 4'd2; wed = 4'd2; apply_and_check("R3");
    check("R3", ob, 32'hE0E0_0001); check("R8", oa, rfa);
    // R1: call and jump override A, ret does not
    base(); exd = 4'd1; cls = 2'd1; apply_and_check("R1"); check("R1", oa, npc);
    cls = 2'd2; apply_and_check("R1"); check("R1", oa, npc);
    cls = 2'd3; apply_and_check("R1"); check("R1", oa, 32'hE0E0_0001);
    // R3: B never overridden by PC
    cls = 2'd1; sb = 4'd1; apply_and_check("R3"); check("R3", ob, 32'hE0E0_0001);
    // R5: source 0xF never matches even when destinations are 0xF
    base(); sa = 4'hF; sb = 4'hF; apply_and_check("R5");
    check("R5", oa, rfa); check("R5", ob, rfb);
    // R8: A and B pick different stages
    base(); sa = 4'd3; sb = 4'd4; mmd = 4'd3; wed = 4'd4; apply_and_check("R8");
    check("R8", oa, 32'h3131_0002); check("R8", ob, 32'h5E5E_0005);

    // random with narrow ID pool, R2 R3 R6
    for (int i = 0; i < 3000; i++) begin
      logic [3:0] r0 = 4'($urandom_range(0, 14));
      logic [3:0] r1 = 4'($urandom_range(0, 15));
      cls = 2'($urandom_range(0, 3)); npc = $urandom;
      rfa = $urandom; rfb = $urandom; exv = $urandom; mav = $urandom;
      mlv = $urandom; wav = $urandom; wlv = $urandom;
      exd = pick(r0, r1); med = pick(r0, r1); mmd = pick(r0, r1);
      wed = pick(r0, r1); wmd = pick(r0, r1);
      sa = pick(r0, r1); sb = pick(r1, r0);
      apply_and_check("R6");
    end
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #2000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule